// File: doc/BRIEF.md
# Multi-Rate Electrical Link Distributor

This block takes the 80-bit payload field of each frame and the 2-bit slow-control field that rides beside it, and spreads them over a bank of low-speed serial output links plus one dedicated slow lane. The links form five groups of eight. Each group has a 2-bit rate setting that selects 80, 160 or 320 Mb/s, or switches the group off. At the 40 MHz frame rate a link carries 2, 4 or 8 bits per frame. A group therefore uses 8, 4 or 2 of its links, and the links it does not use are held at zero. Each group also drives one forwarded clock, and the slow lane always runs at 80 Mb/s with a clock of its own.

The block runs on one fast clock at twice the fastest link bit rate, so a frame lasts 16 cycles. A free-running phase counter marks the frame boundary. The block raises `frame_take` in the last cycle of each frame, and the payload, slow-control bits and rate settings on its inputs are captured at the rising edge that ends that cycle. A rate change therefore takes effect only at a frame boundary. Group g takes payload bits [16g+15:16g]. Within a group the active links take consecutive pieces of that slice in ascending link order, and each link sends its piece most significant bit first.

Top module: `elink_distributor`

## Requirements
- R1: While `rst_n` is low, every link data output, every group clock, `sc_dout` and `sc_clk` are 0.
- R2: A frame lasts 16 clock cycles. `frame_take` is high in exactly one cycle of each frame, which is the first cycle after reset and then every 16th cycle. `field_in`, `sc_in` and `rate_cfg` are sampled only at the rising edge that ends a `frame_take` cycle, and the first bit of the new frame appears in the next cycle.
- R3: Group g (link indices 8g to 8g+7) carries `field_in[16g+15:16g]`, and `rate_cfg[2g+1:2g]` sets its rate.
- R4: Rate code 0 (80 Mb/s): link k of a group sends slice bits 15-2k and then 14-2k, each held for 8 cycles.
- R5: Rate code 1 (160 Mb/s): links 0 to 3 each send 4 bits, starting at slice bit 15-4k and going downward, each bit held for 4 cycles.
- R6: Rate code 2 (320 Mb/s): links 0 and 1 each send 8 bits, starting at slice bit 15-8k and going downward, each bit held for 2 cycles. No link output changes between the two cycles of a 2-cycle pair.
- R7: Links that the rate does not use drive 0: links 4 to 7 at code 1, and links 2 to 7 at code 2.
- R8: Rate code 3 switches the group off for the whole frame: all its links and its clock are 0.
- R9: An active group's clock has a period of one bit time. It is low in the first half of each bit and high in the second half, so it is low in the first cycle of every frame and rises in the middle of each bit.
- R10: The slow lane sends `sc_in[1]` and then `sc_in[0]`, each held for 8 cycles. `sc_clk` has the 80 Mb/s shape described in R9.
- R11: Changing `field_in`, `sc_in` or `rate_cfg` in the middle of a frame has no effect on that frame's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the fastest link bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| field_in | input | 80 | Payload field of the next frame |
| sc_in | input | 2 | Slow-control field of the next frame |
| rate_cfg | input | 10 | Per-group rate code, 2 bits per group: 0=80, 1=160, 2=320 Mb/s, 3=off |
| frame_take | output | 1 | High in the last cycle of a frame; inputs are captured at its closing edge |
| link_dout | output | 40 | Serial data, one bit per link, link index = 8*group + lane |
| group_clk | output | 5 | Forwarded clock per group |
| sc_dout | output | 1 | Slow-lane serial data |
| sc_clk | output | 1 | Slow-lane forwarded clock |

## Verification
A phase counter that is off by even one count shifts every link's bit boundaries and the `frame_take` pulse together. This shows at the ports within one frame, either as a clock that is not low in the first cycle of a frame or as data that changes in the middle of a bit. A lane register loaded with the wrong piece of the slice, or with a stale rate, produces wrong bits in the very first bit time of the next frame, and unused links that should be zero light up at the same time. Sweeping every combination of the five group rates, with changing payloads and with the inputs scrambled in the middle of each frame, exposes each of these faults within about 16 cycles of where it happens.

// File: rtl/elink_pkg.sv
package elink_pkg;

   typedef enum logic [1:0] {
      RATE_80  = 2'd0,
      RATE_160 = 2'd1,
      RATE_320 = 2'd2,
      RATE_OFF = 2'd3
   } rate_e;

   // bits per link per frame at the fastest rate; fixed by 320 Mb/s over a 40 MHz frame
   localparam int MAX_BITS  = 8;
   // fast clock runs at twice the fastest bit rate
   localparam int FRAME_CYC = 2 * MAX_BITS;
   localparam int PH_W      = $clog2(FRAME_CYC);

endpackage

// File: rtl/elink_phase_gen.sv
module elink_phase_gen
   import elink_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] ph,
   output logic [PH_W-1:0] ph_nxt,
   output logic            load
);

   // frame length must be a power of two so the counter wraps on its own
   if ((1 << PH_W) != FRAME_CYC) begin : g_bad_frame
      $error("frame length must be a power of two");
   end

   always_comb begin
      ph_nxt = ph + 1'b1;
      load   = &ph;
   end

   // reset parks the counter on the last phase, so the first edge loads a frame
   always_ff @(posedge clk) begin
      if (!rst_n) ph <= '1;
      else        ph <= ph_nxt;
   end

endmodule

// File: rtl/elink_group.sv
module elink_group
   import elink_pkg::*;
#(
   parameter int LANES   = 8,
   parameter int SLICE_W = 2 * LANES
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [PH_W-1:0]    ph,
   input  logic [PH_W-1:0]    ph_nxt,
   input  logic [SLICE_W-1:0] slice,
   input  logic [1:0]         rate_in,
   output logic [LANES-1:0]   dout,
   output logic               fclk,
   output logic [1:0]         rate_o
);

   if (SLICE_W != 2 * LANES || SLICE_W < MAX_BITS) begin : g_bad_slice
      $error("slice width must be twice the lane count and at least MAX_BITS");
   end

   rate_e rate_q;
   rate_e eff_rate;
   logic  shift_en;
   logic  clk_nxt;

   // piece of the slice for lane k, left-aligned, unused bits cleared
   function automatic logic [MAX_BITS-1:0] pick(input logic [SLICE_W-1:0] s,
                                                input rate_e r, input int k);
      logic [SLICE_W-1:0] t;
      int                 b;
      b = 2 << int'(r);
      if (r == RATE_OFF || k >= (LANES >> int'(r))) return '0;
      t = s << (k * b);
      return t[SLICE_W-1 -: MAX_BITS] & ~({MAX_BITS{1'b1}} >> b);
   endfunction

   always_comb begin
      eff_rate = load ? rate_e'(rate_in) : rate_q;
      unique case (rate_q)
         RATE_80:  shift_en = &ph[2:0];
         RATE_160: shift_en = &ph[1:0];
         RATE_320: shift_en = ph[0];
         default:  shift_en = 1'b0;
      endcase
      unique case (eff_rate)
         RATE_80:  clk_nxt = ph_nxt[2];
         RATE_160: clk_nxt = ph_nxt[1];
         RATE_320: clk_nxt = ph_nxt[0];
         default:  clk_nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= RATE_OFF;
         fclk   <= 1'b0;
      end else begin
         if (load) rate_q <= rate_e'(rate_in);
         fclk <= clk_nxt;
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [MAX_BITS-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n)        sh <= '0;
         else if (load)     sh <= pick(slice, rate_e'(rate_in), k);
         else if (shift_en) sh <= {sh[MAX_BITS-2:0], 1'b0};
      end
      assign dout[k] = sh[MAX_BITS-1];
   end

   assign rate_o = rate_q;

endmodule

// File: rtl/elink_slow_lane.sv
module elink_slow_lane
   import elink_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [PH_W-1:0] ph,
   input  logic [PH_W-1:0] ph_nxt,
   input  logic [1:0]      bits_in,
   output logic            dout,
   output logic            lclk
);

   logic [1:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         lclk <= 1'b0;
      end else begin
         if (load)           sh <= bits_in;
         else if (&ph[2:0])  sh <= {sh[0], 1'b0};
         lclk <= ph_nxt[2];
      end
   end

   assign dout = sh[1];

endmodule

// File: rtl/elink_distributor.sv
module elink_distributor
   import elink_pkg::*;
#(
   parameter int GROUPS = 5,
   parameter int LANES  = 8
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2*LANES*GROUPS-1:0] field_in,
   input  logic [1:0]                sc_in,
   input  logic [2*GROUPS-1:0]       rate_cfg,
   output logic                      frame_take,
   output logic [LANES*GROUPS-1:0]   link_dout,
   output logic [GROUPS-1:0]         group_clk,
   output logic                      sc_dout,
   output logic                      sc_clk
);

   localparam int SLICE_W = 2 * LANES;

   if (LANES < 4 || (LANES % 4) != 0) begin : g_bad_lanes
      $error("LANES must be a non-zero multiple of 4");
   end
   if (GROUPS < 1) begin : g_bad_groups
      $error("GROUPS must be at least 1");
   end

   logic [PH_W-1:0]     ph;
   logic [PH_W-1:0]     ph_nxt;
   logic                load;
   logic [2*GROUPS-1:0] grp_rate;

   elink_phase_gen phase_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ph     (ph),
      .ph_nxt (ph_nxt),
      .load   (load)
   );

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      elink_group #(.LANES(LANES), .SLICE_W(SLICE_W)) grp_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (load),
         .ph      (ph),
         .ph_nxt  (ph_nxt),
         .slice   (field_in[g*SLICE_W +: SLICE_W]),
         .rate_in (rate_cfg[2*g +: 2]),
         .dout    (link_dout[g*LANES +: LANES]),
         .fclk    (group_clk[g]),
         .rate_o  (grp_rate[2*g +: 2])
      );
   end

   elink_slow_lane slow_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .ph      (ph),
      .ph_nxt  (ph_nxt),
      .bits_in (sc_in),
      .dout    (sc_dout),
      .lclk    (sc_clk)
   );

   assign frame_take = load;

endmodule

// File: rtl/elink_distributor_chk.sv
module elink_distributor_chk #(
   parameter int GROUPS = 5,
   parameter int LANES  = 8
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    frame_take,
   input logic [3:0]              ph,
   input logic [2*GROUPS-1:0]     grp_rate,
   input logic [LANES*GROUPS-1:0] link_dout,
   input logic [GROUPS-1:0]       group_clk,
   input logic                    sc_dout,
   input logic                    sc_clk
);

   // independent frame counter, zero in the first cycle after reset
   logic [3:0] cyc;
   always_ff @(posedge clk) begin
      if (!rst_n) cyc <= '0;
      else        cyc <= cyc + 1'b1;
   end

   // R2
   frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_take == (cyc == 4'd0));

   // R6
   pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph[0] |-> $stable(link_dout));

   // R10
   slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph[2:0] != 3'd0) |-> $stable(sc_dout));

   // R9
   clk_low_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == 4'd0) |-> (group_clk == '0 && !sc_clk));

   // R11
   rate_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_take |=> $stable(grp_rate));

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      // R8
      off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_rate[2*g +: 2] == 2'd3) |->
            (!group_clk[g] && link_dout[g*LANES +: LANES] == '0));
      // R7
      unused_320_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_rate[2*g +: 2] == 2'd2) |-> (link_dout[g*LANES+2 +: LANES-2] == '0));
      // R7
      unused_160_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_rate[2*g +: 2] == 2'd1) |-> (link_dout[g*LANES+4 +: LANES-4] == '0));
   end

endmodule

bind elink_distributor elink_distributor_chk #(.GROUPS(GROUPS), .LANES(LANES)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_take (frame_take),
   .ph         (ph),
   .grp_rate   (grp_rate),
   .link_dout  (link_dout),
   .group_clk  (group_clk),
   .sc_dout    (sc_dout),
   .sc_clk     (sc_clk)
);

// File: tb/elink_distributor_tb_top.sv
`timescale 1ns/1ps
module elink_distributor_tb_top;

   localparam int GROUPS = 5;
   localparam int LANES  = 8;
   localparam int SW     = 2 * LANES;

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic [SW*GROUPS-1:0]    field_in;
   logic [1:0]              sc_in;
   logic [2*GROUPS-1:0]     rate_cfg;
   logic                    frame_take;
   logic [LANES*GROUPS-1:0] link_dout;
   logic [GROUPS-1:0]       group_clk;
   logic                    sc_dout;
   logic                    sc_clk;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2 clk = ~clk;

   elink_distributor #(.GROUPS(GROUPS), .LANES(LANES)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .field_in   (field_in),
      .sc_in      (sc_in),
      .rate_cfg   (rate_cfg),
      .frame_take (frame_take),
      .link_dout  (link_dout),
      .group_clk  (group_clk),
      .sc_dout    (sc_dout),
      .sc_clk     (sc_clk)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [LANES-1:0] exp_lanes(input logic [SW-1:0] s, input int r, input int p);
      logic [LANES-1:0] v = '0;
      int b, per, n;
      if (r == 3) return '0;
      b   = 2 << r;
      per = 8 >> r;
      n   = LANES >> r;
      for (int k = 0; k < n; k++) v[k] = s[SW - 1 - k*b - p/per];
      return v;
   endfunction

   function automatic logic exp_clk(input int r, input int p);
      int per;
      if (r == 3) return 1'b0;
      per = 8 >> r;
      return (p % per) >= per / 2;
   endfunction

   task automatic run_frame(input logic [SW*GROUPS-1:0] f, input logic [1:0] sc,
                            input logic [2*GROUPS-1:0] rates);
      int guard = 0;
      while (!frame_take && guard < 40) begin
         @(negedge clk);
         guard++;
      end
      field_in = f;
      sc_in    = sc;
      rate_cfg = rates;
      for (int p = 0; p < 16; p++) begin
         @(negedge clk);
         // R2: boundary marker only in the last cycle of the frame
         check("R2 frame_take", 64'(frame_take), 64'(p == 15));
         for (int g = 0; g < GROUPS; g++) begin
            int r = int'(rates[2*g +: 2]);
            logic [LANES-1:0] e = exp_lanes(f[g*SW +: SW], r, p);
            logic [LANES-1:0] a = link_dout[g*LANES +: LANES];
            case (r)
               0: check("R3 R4 data 80", 64'(a), 64'(e));
               1: begin
                  check("R3 R5 data 160", 64'(a[3:0]), 64'(e[3:0]));
                  check("R7 unused at 160", 64'(a[LANES-1:4]), 64'(0));
               end
               2: begin
                  check("R3 R6 data 320", 64'(a[1:0]), 64'(e[1:0]));
                  check("R7 unused at 320", 64'(a[LANES-1:2]), 64'(0));
               end
               default: check("R8 group off", 64'({group_clk[g], a}), 64'(0));
            endcase
            check("R9 group clock", 64'(group_clk[g]), 64'(exp_clk(r, p)));
         end
         check("R10 slow data", 64'(sc_dout), 64'(sc[1 - p/8]));
         check("R10 slow clock", 64'(sc_clk), 64'(exp_clk(0, p)));
         // R11: scramble every input mid-frame; outputs must not follow
         if (p == 5) begin
            field_in = ~f;
            sc_in    = ~sc;
            rate_cfg = ~rates;
         end
      end
   endtask

   initial begin
      rst_n    = 1'b0;
      field_in = '0;
      sc_in    = '0;
      rate_cfg = '0;
      repeat (5) @(negedge clk);
      // R1: quiet outputs during reset
      check("R1 reset links", 64'(link_dout), 64'(0));
      check("R1 reset clocks", 64'({group_clk, sc_dout, sc_clk}), 64'(0));
      rst_n = 1'b1;
      // R2: first cycle after reset is a capture cycle
      check("R2 first frame_take", 64'(frame_take), 64'(1));
      for (int fr = 0; fr < 1024; fr++) begin
         logic [SW*GROUPS-1:0] fv;
         fv = {32'(fr) * 32'h9E3779B1, ~(32'(fr) * 32'h85EBCA6B), 16'(fr) ^ 16'h5A5A};
         run_frame(fv, 2'(fr), 10'(fr));
      end
      run_frame('1, 2'b11, 10'b1010101010);
      run_frame('0, 2'b00, 10'b0000000000);
      run_frame({5{16'h8001}}, 2'b10, 10'b0001101100);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule